// File: doc/BRIEF.md
# Misaligned Access Bus Splitter

This block sits between a CPU load/store port and a 32-bit big-endian external bus. It accepts one request at a time. A request carries an address, a size (byte, halfword or word), a direction and, for stores, write data. The block turns the request into the shortest run of naturally aligned bus transfers that covers the requested bytes. Each transfer is announced with a one-clock active-low start strobe and completes when the target returns an active-low acknowledge.

Fragments are chosen greedily from the current address and the number of bytes still outstanding. The widest aligned size that fits is used each time. Store bytes are routed onto the byte lanes that match each fragment's address, and the original big-endian byte order is kept. Load fragments are gathered into a staging word. The result is returned right-justified and zero-extended, together with a one-clock completion pulse.

Top module: `misalign_splitter`

## Requirements
- R1: After reset, ts_no and rdwr_no are high, busy_o and done_o are low, and no transfer starts until a request is accepted.
- R2: A word access (size_i 00) at an address with bits [1:0] = 00 produces exactly one transfer with tsiz_o 00 at that address.
- R3: An aligned halfword (size_i 10, even address not at word offset 3) or any byte access (size_i 01) produces exactly one transfer, with tsiz_o 10 or 01 respectively.
- R4: A word access at word offset 3 produces, in this order, a byte at A, a halfword at A+1 and a byte at A+3.
- R5: A word access at word offset 2 produces halfwords at A and A+2. A word access at offset 1 produces a byte at A, a halfword at A+1 and a byte at A+3.
- R6: A halfword access at an odd address produces two byte transfers, at A and A+1.
- R7: On stores, bus lane o (o = address bits [1:0]) is bus_data_o[31-8o -: 8]. Fragment bytes are taken from the store data in big-endian order (most significant requested byte first), and unused lanes are driven to zero. On loads, bus_data_o is zero.
- R8: On loads, each acknowledged fragment's lanes are merged into the result, and rdata_o holds the requested bytes right-justified and zero-extended while done_o is high.
- R9: ts_no is low for exactly one clock per fragment. The next strobe comes only after the previous acknowledge, and bus_addr_o, tsiz_o and rdwr_no stay stable while an acknowledge is awaited, including across wait states.
- R10: done_o pulses for one clock in the cycle after the last acknowledge. A request presented in that same cycle is accepted, and requests presented while busy_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid, sampled while idle |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | 01 byte, 10 halfword, 00 word (11 treated as word) |
| addr_i | input | 32 | Byte address of the access |
| wdata_i | input | 32 | Store data, right-justified |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 32 | Load result, right-justified |
| ts_no | output | 1 | Transfer start strobe, active low |
| rdwr_no | output | 1 | 1 = read, 0 = write |
| tsiz_o | output | 2 | Transfer size, same encoding as size_i |
| bus_addr_o | output | 26 | Bus address lines, low 26 address bits |
| bus_data_o | output | 32 | Write data lanes, byte lane 0 in bits 31:24 |
| bus_data_i | input | 32 | Read data lanes |
| ta_ni | input | 1 | Transfer acknowledge, active low |

## Verification
Two events can land in the same clock: the completion pulse of one request, and the acceptance of the next request. The bench raises a new request at the falling edge where done_o is first seen high. It then checks that busy_o is high one clock later, and that the second request's fragments and result are correct and not mixed with the first. A second directed case holds the acknowledge off for several clocks so that strobe uniqueness and address hold can be judged across wait states.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
  localparam int unsigned LANES   = 4;
  localparam int unsigned DATA_W  = 8 * LANES;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned BUS_AW  = 26;
  localparam int unsigned OFF_W   = $clog2(LANES);
  localparam int unsigned CNT_W   = OFF_W + 1;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10
  } bsize_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT
  } st_e;

  function automatic logic [CNT_W-1:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = CNT_W'(1);
      SZ_HALF: size_bytes = CNT_W'(2);
      default: size_bytes = CNT_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/frag_plan.sv
module frag_plan
  import splitter_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  input  logic [CNT_W-1:0] remain_i,
  output logic [1:0]       tsiz_o,
  output logic [CNT_W-1:0] nbytes_o
);
  // widest naturally aligned piece that does not overrun the request
  always_comb begin
    if (off_i == '0 && remain_i == CNT_W'(4)) begin
      tsiz_o   = SZ_WORD;
      nbytes_o = CNT_W'(4);
    end else if (!off_i[0] && remain_i >= CNT_W'(2)) begin
      tsiz_o   = SZ_HALF;
      nbytes_o = CNT_W'(2);
    end else begin
      tsiz_o   = SZ_BYTE;
      nbytes_o = CNT_W'(1);
    end
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import splitter_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  logic [OFF_W-1:0]  idx_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  input  logic [DATA_W-1:0] wbuf_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic [DATA_W-1:0] rbuf_i,
  output logic [DATA_W-1:0] lanes_o,
  output logic [DATA_W-1:0] rbuf_nxt_o
);
  // byte b of a big-endian word sits at bits [DATA_W-1-8b -: 8]
  for (genvar j = 0; j < LANES; j++) begin : g_wlane
    always_comb begin
      int src;
      src = int'(idx_i) + j - int'(off_i);
      if (j >= int'(off_i) && j < int'(off_i) + int'(nbytes_i))
        lanes_o[8*(LANES-1-j) +: 8] = wbuf_i[8*(LANES-1-(src % LANES)) +: 8];
      else
        lanes_o[8*(LANES-1-j) +: 8] = 8'h00;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_rbyte
    always_comb begin
      int lane;
      lane = int'(off_i) + k - int'(idx_i);
      if (k >= int'(idx_i) && k < int'(idx_i) + int'(nbytes_i))
        rbuf_nxt_o[8*(LANES-1-k) +: 8] = bus_rdata_i[8*(LANES-1-(lane % LANES)) +: 8];
      else
        rbuf_nxt_o[8*(LANES-1-k) +: 8] = rbuf_i[8*(LANES-1-k) +: 8];
    end
  end
endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
  import splitter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ts_no,
  output logic              rdwr_no,
  output logic [1:0]        tsiz_o,
  output logic [BUS_AW-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              ta_ni
);
  st_e               state_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [CNT_W-1:0]  remain_q, total_q;
  logic [OFF_W-1:0]  idx_q;
  logic              we_q, done_q;
  logic [DATA_W-1:0] wbuf_q, rbuf_q, rdata_q;

  logic [CNT_W-1:0]  frag_n, req_n;
  logic [DATA_W-1:0] lanes, rbuf_nxt;
  logic              last_ack;

  frag_plan u_plan (
    .off_i    (cur_addr_q[OFF_W-1:0]),
    .remain_i (remain_q),
    .tsiz_o   (tsiz_o),
    .nbytes_o (frag_n)
  );

  lane_steer u_steer (
    .off_i       (cur_addr_q[OFF_W-1:0]),
    .idx_i       (idx_q),
    .nbytes_i    (frag_n),
    .wbuf_i      (wbuf_q),
    .bus_rdata_i (bus_data_i),
    .rbuf_i      (rbuf_q),
    .lanes_o     (lanes),
    .rbuf_nxt_o  (rbuf_nxt)
  );

  assign req_n    = size_bytes(size_i);
  assign last_ack = (state_q == ST_WAIT) && !ta_ni && (remain_q == frag_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_addr_q <= '0;
      remain_q   <= '0;
      total_q    <= '0;
      idx_q      <= '0;
      we_q       <= 1'b0;
      done_q     <= 1'b0;
      wbuf_q     <= '0;
      rbuf_q     <= '0;
      rdata_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_i) begin
          state_q    <= ST_ADDR;
          cur_addr_q <= addr_i;
          remain_q   <= req_n;
          total_q    <= req_n;
          idx_q      <= '0;
          we_q       <= we_i;
          // left-align so requested byte 0 is the most significant
          wbuf_q     <= wdata_i << (8 * (LANES - int'(req_n)));
          rbuf_q     <= '0;
        end
        ST_ADDR: state_q <= ST_WAIT;
        ST_WAIT: if (!ta_ni) begin
          cur_addr_q <= cur_addr_q + ADDR_W'(frag_n);
          remain_q   <= remain_q - frag_n;
          idx_q      <= idx_q + frag_n[OFF_W-1:0];
          if (!we_q) rbuf_q <= rbuf_nxt;
          if (last_ack) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            if (!we_q) rdata_q <= rbuf_nxt >> (8 * (LANES - int'(total_q)));
          end else begin
            state_q <= ST_ADDR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign ts_no      = (state_q != ST_ADDR);
  assign rdwr_no    = !we_q;
  assign bus_addr_o = cur_addr_q[BUS_AW-1:0];
  assign bus_data_o = we_q ? lanes : '0;

  // R9: strobe lasts one clock
  a_r9_ts_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_no |=> ts_no);
  // R9: address, size and direction held while awaiting acknowledge
  a_r9_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && ta_ni && !($rose(busy_o))) |=>
      ($stable(bus_addr_o) && $stable(tsiz_o) && $stable(rdwr_no)) || !busy_o || !ts_no);
  // R2: full-word transfers only on word boundaries
  a_r2_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ts_no && tsiz_o == SZ_WORD) |-> bus_addr_o[1:0] == 2'b00);
  // R6: halfword transfers never start at an odd address
  a_r6_half_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ts_no && tsiz_o == SZ_HALF) |-> !bus_addr_o[0]);
  // R10: completion pulse follows an acknowledge and lasts one clock
  a_r10_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(!ta_ni));
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R1: no strobe while idle
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ts_no);
endmodule

// File: tb/misalign_splitter_tb.sv
module misalign_splitter_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;
  localparam logic [31:0] BASE = 32'h0290_0000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic        busy_o, done_o, ts_no, rdwr_no;
  logic [31:0] rdata_o, bus_data_o, bus_data_i;
  logic [1:0]  tsiz_o;
  logic [25:0] bus_addr_o;
  logic        ta_ni;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  misalign_splitter u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .size_i, .addr_i, .wdata_i,
    .busy_o, .done_o, .rdata_o, .ts_no, .rdwr_no, .tsiz_o,
    .bus_addr_o, .bus_data_o, .bus_data_i, .ta_ni
  );

  // bus target: memory byte at low nibble a reads as 8'hA0 + a
  int          ws = 0, wcnt = 0, nlog = 0;
  logic        pend = 1'b0;
  logic [25:0] cur_a = '0;
  logic [25:0] log_a [8];
  logic [1:0]  log_s [8];
  logic [31:0] log_d [8];
  logic        log_rw [8];

  always @(posedge clk_i) begin
    if (pend) begin
      if (wcnt == 0) pend <= 1'b0;
      else wcnt <= wcnt - 1;
    end
    if (rst_ni && !ts_no) begin
      pend  <= 1'b1;
      wcnt  <= ws;
      cur_a <= bus_addr_o;
      if (nlog < 8) begin
        log_a[nlog]  <= bus_addr_o;
        log_s[nlog]  <= tsiz_o;
        log_d[nlog]  <= bus_data_o;
        log_rw[nlog] <= rdwr_no;
      end
      nlog <= nlog + 1;
    end
  end
  assign ta_ni = !(pend && wcnt == 0);
  always_comb
    for (int j = 0; j < 4; j++)
      bus_data_i[8*(3-j) +: 8] = 8'hA0 + {4'h0, cur_a[3:2], 2'b00} + 8'(j);

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic             we;
    logic [1:0]       sz;
    logic [3:0]       off;
    logic [31:0]      wd;
    logic [1:0]       nf;
    logic [3:0]       rq;
    logic [2:0][3:0]  fa;
    logic [2:0][1:0]  fs;
    logic [2:0][31:0] fd;
    logic [31:0]      rd;
  } vec_t;

  // fragment fields are listed last-to-first: {frag2, frag1, frag0}
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b00, 4'h0, 32'h11223344, 2'd1, 4'd2, {4'h0,4'h0,4'h0}, {2'b00,2'b00,2'b00}, {32'h0,32'h0,32'h11223344}, 32'h0},
    '{1'b1, 2'b00, 4'h3, 32'h01234567, 2'd3, 4'd4, {4'h6,4'h4,4'h3}, {2'b01,2'b10,2'b01}, {32'h00006700,32'h23450000,32'h00000001}, 32'h0},
    '{1'b0, 2'b00, 4'h2, 32'h0,        2'd2, 4'd5, {4'h0,4'h4,4'h2}, {2'b00,2'b10,2'b10}, {32'h0,32'h0,32'h0}, 32'hA2A3A4A5},
    '{1'b0, 2'b00, 4'h1, 32'h0,        2'd3, 4'd5, {4'h4,4'h2,4'h1}, {2'b01,2'b10,2'b01}, {32'h0,32'h0,32'h0}, 32'hA1A2A3A4},
    '{1'b1, 2'b10, 4'h5, 32'h0000BEEF, 2'd2, 4'd6, {4'h0,4'h6,4'h5}, {2'b00,2'b01,2'b01}, {32'h0,32'h0000EF00,32'h00BE0000}, 32'h0},
    '{1'b0, 2'b10, 4'h6, 32'h0,        2'd1, 4'd3, {4'h0,4'h0,4'h6}, {2'b00,2'b00,2'b10}, {32'h0,32'h0,32'h0}, 32'h0000A6A7},
    '{1'b1, 2'b01, 4'h7, 32'h0000005A, 2'd1, 4'd3, {4'h0,4'h0,4'h7}, {2'b00,2'b00,2'b01}, {32'h0,32'h0,32'h0000005A}, 32'h0},
    '{1'b0, 2'b01, 4'h9, 32'h0,        2'd1, 4'd3, {4'h0,4'h0,4'h9}, {2'b00,2'b00,2'b01}, {32'h0,32'h0,32'h0}, 32'h000000A9},
    '{1'b0, 2'b10, 4'h3, 32'h0,        2'd2, 4'd6, {4'h0,4'h4,4'h3}, {2'b00,2'b01,2'b01}, {32'h0,32'h0,32'h0}, 32'h0000A3A4},
    '{1'b0, 2'b00, 4'h8, 32'h0,        2'd1, 4'd2, {4'h0,4'h0,4'h8}, {2'b00,2'b00,2'b00}, {32'h0,32'h0,32'h0}, 32'hA8A9AAAB},
    '{1'b1, 2'b10, 4'h2, 32'h00001234, 2'd1, 4'd3, {4'h0,4'h0,4'h2}, {2'b00,2'b00,2'b10}, {32'h0,32'h0,32'h00001234}, 32'h0},
    '{1'b0, 2'b00, 4'h3, 32'h0,        2'd3, 4'd4, {4'h6,4'h4,4'h3}, {2'b01,2'b10,2'b01}, {32'h0,32'h0,32'h0}, 32'hA3A4A5A6}
  };

  function automatic string rtag(input logic [3:0] id);
    case (id)
      4'd2: rtag = "R2";
      4'd3: rtag = "R3";
      4'd4: rtag = "R4";
      4'd5: rtag = "R5";
      default: rtag = "R6";
    endcase
  endfunction

  logic [31:0] got_rd;

  task automatic issue(input logic we, input logic [1:0] sz, input logic [3:0] off, input logic [31:0] wd);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; size_i = sz; addr_i = BASE | {28'h0, off}; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 60; i++) begin
      if (done_o) break;
      @(negedge clk_i);
    end
    check("R10", "done pulse", {31'h0, done_o}, 32'h1);
    got_rd = rdata_o;
  endtask

  initial begin
    // R1: reset state
    #(CLK_PERIOD*2);
    @(negedge clk_i);
    check("R1", "ts_no", {31'h0, ts_no}, 32'h1);
    check("R1", "rdwr_no", {31'h0, rdwr_no}, 32'h1);
    check("R1", "busy_o", {31'h0, busy_o}, 32'h0);
    check("R1", "done_o", {31'h0, done_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1", "no transfer before request", nlog, 0);

    for (int v = 0; v < NV; v++) begin
      nlog = 0;
      issue(VECS[v].we, VECS[v].sz, VECS[v].off, VECS[v].wd);
      wait_done();
      check(rtag(VECS[v].rq), "fragment count", nlog, {30'h0, VECS[v].nf});
      for (int f = 0; f < int'(VECS[v].nf); f++) begin
        check(rtag(VECS[v].rq), "fragment addr", {6'h0, log_a[f]}, BASE | {28'h0, VECS[v].fa[f]});
        check(rtag(VECS[v].rq), "fragment size", {30'h0, log_s[f]}, {30'h0, VECS[v].fs[f]});
        check("R7", "fragment lanes", log_d[f], VECS[v].fd[f]);
        check("R9", "fragment direction", {31'h0, log_rw[f]}, {31'h0, !VECS[v].we});
      end
      if (!VECS[v].we) check("R8", "merged load", got_rd, VECS[v].rd);
      @(negedge clk_i);
    end

    // R9: wait states on a three-piece store
    ws = 3; nlog = 0;
    issue(1'b1, 2'b00, 4'h3, 32'hCAFEF00D);
    wait_done();
    check("R9", "strobes with wait states", nlog, 3);
    check("R9", "piece 2 addr", {6'h0, log_a[1]}, BASE | 32'h4);
    check("R7", "piece 2 lanes", log_d[1], 32'hFEF00000);
    check("R7", "piece 3 lanes", log_d[2], 32'h00000D00);
    ws = 0;
    @(negedge clk_i);

    // R10: new request accepted in the completion cycle
    nlog = 0;
    issue(1'b0, 2'b00, 4'h3, 32'h0);
    wait_done();
    check("R8", "first of back-to-back", got_rd, 32'hA3A4A5A6);
    req_i = 1'b1; we_i = 1'b0; size_i = 2'b01; addr_i = BASE | 32'h9;
    @(negedge clk_i);
    req_i = 1'b0;
    check("R10", "accepted in done cycle", {31'h0, busy_o}, 32'h1);
    wait_done();
    check("R10", "second result", got_rd, 32'h000000A9);
    check("R10", "total pieces", nlog, 4);
    @(negedge clk_i);

    // R10: request while busy is ignored
    nlog = 0;
    issue(1'b1, 2'b00, 4'h0, 32'h55667788);
    req_i = 1'b1; we_i = 1'b0; size_i = 2'b10; addr_i = BASE | 32'h6;
    @(negedge clk_i);
    req_i = 1'b0;
    wait_done();
    repeat (4) @(negedge clk_i);
    check("R10", "busy request dropped", nlog, 1);
    check("R10", "idle after drop", {31'h0, busy_o}, 32'h0);
    check("R2", "word lanes", log_d[0], 32'h55667788);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule